// File: doc/BRIEF.md
# UART Transmit Watermark Interrupt

This block is the transmit half of a 16550-style UART register file. Bytes written by software go into a transmit FIFO whose depth is 32, 64 or 128 entries. A one-cycle drain strobe from the serial shifter removes the oldest entry. The block raises the standard transmitter-empty interrupt, which software enables, identifies, acknowledges and clears through the usual register set.

Two extra registers change what that interrupt means. The first is a feature register, whose bit 0 turns on watermark mode. The second holds an 8-bit level. In watermark mode the interrupt fires when the FIFO fill has dropped to the programmed level, rather than only when the FIFO is fully empty. Software programs the level as depth minus its burst size. Each interrupt then guarantees room for one whole burst of writes.

Registers sit on 32-bit boundaries, so register n lives at byte address 4·n. A register decodes only when address bits 1:0 are zero.

Top module: `uart_txwm`

## Requirements
- R1: After reset: `irq` is 0, `tx_level` is 0, `tx_ovf` is 0, and a read of the identification register at 0x08 returns 0xC1.
- R2: Register map (byte addresses):
  - Holding register (write-only push) at 0x00.
  - Interrupt enable at 0x04. Bits 3:0 are stored and read back; bit 1 enables the transmit interrupt.
  - Identification register (read) at 0x08.
  - Feature register at 0x100. Only bit 0 is stored, and the other bits read 0.
  - Watermark level at 0x104. All 8 bits are stored as written.
- R3: The FIFO is first-in first-out. A write to 0x00 appends `wdata`, and a pulse on `tx_pop` removes the oldest entry. `tx_data` shows the oldest entry, and `tx_level` shows the fill count. Both update one cycle after the access.
- R4: A write to 0x00 while the FIFO is full is dropped, leaving the level and contents unchanged. It also sets `tx_ovf`, which stays 1 until reset.
- R5: With feature bit 0 clear, the transmit condition holds only when `tx_level` is 0.
- R6: With feature bit 0 set, the transmit condition holds when `tx_level` is at most the watermark level.
- R7: A watermark level of depth−1 or more reads back unchanged, but the compare saturates. The condition then holds whenever the FIFO is not full.
- R8: The identification register reads 0xC2 while the transmit interrupt is active, and 0xC1 otherwise. `irq` is 1 exactly while the transmit interrupt is active.
- R9: A read of 0x08 that returns 0xC2 clears the active interrupt, so `irq` is 0 on the next cycle. A write to 0x00 also clears it.
- R10: Once cleared, the interrupt is re-armed in only two cases:
  - the condition becomes true after being false;
  - enable bit 1 goes from 0 to 1 while the condition holds.
  In either case `irq` rises two cycles after the triggering access.
- R11: The interrupt is never active while enable bit 1 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe (side effects at the clock edge) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 9 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| tx_pop | input | 1 | Drain strobe from the serial shifter |
| tx_data | output | 8 | Oldest FIFO entry |
| tx_level | output | $clog2(DEPTH+1) | FIFO fill count |
| irq | output | 1 | Transmit interrupt |
| tx_ovf | output | 1 | Sticky full-write flag |

## Verification
Suppose the fill counter or a pointer goes wrong. Within one cycle that shows as a wrong `tx_level` or `tx_data`, and later as a wrong drain order. Either can be seen by walking a full FIFO out entry by entry.

Suppose the pending latch or its edge detectors go wrong. That shows up as `irq` or the identification code being present or absent when it should not be, two cycles after an access. The threshold boundary (level w+1 versus w) and the saturated level are probed directly. An ack that fails to clear, or a spurious re-arm, appears on `irq` the cycle after the read or write.

// File: rtl/uart_txwm_pkg.sv
package uart_txwm_pkg;

    localparam logic [8:0] A_THR = 9'h000;
    localparam logic [8:0] A_IER = 9'h004;
    localparam logic [8:0] A_IIR = 9'h008;
    localparam logic [8:0] A_FEAT = 9'h100;
    localparam logic [8:0] A_WMLV = 9'h104;

    localparam logic [7:0] IIR_TX = 8'hC2;
    localparam logic [7:0] IIR_NONE = 8'hC1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_THR,
        SEL_IER,
        SEL_IIR,
        SEL_FEAT,
        SEL_WMLV
    } reg_sel_e;

    typedef struct packed {
        logic       rd;
        logic       wr;
        logic [8:0] addr;
        logic [7:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode(input logic [8:0] a);
        reg_sel_e s;
        case (a)
            A_THR:   s = SEL_THR;
            A_IER:   s = SEL_IER;
            A_IIR:   s = SEL_IIR;
            A_FEAT:  s = SEL_FEAT;
            A_WMLV:  s = SEL_WMLV;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic int wm_sat(input logic [7:0] wm, input int depth);
        return (int'(wm) >= depth - 1) ? depth - 1 : int'(wm);
    endfunction

endpackage

// File: rtl/txwm_fifo.sv
module txwm_fifo #(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [7:0]       din,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             ovf
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (level == LVL_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (level != '0);
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (push && full) ovf <= 1'b1;
        end
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> $stable(level));
    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
        int'(level) <= DEPTH);
endmodule

// File: rtl/txwm_regs.sv
module txwm_regs
    import uart_txwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  logic     active,
    output logic     ie_tx,
    output logic     wm_en,
    output logic [7:0] wm_lvl,
    output logic     thr_wr,
    output logic     ack,
    output logic [7:0] rdata
);
    reg_sel_e   sel;
    logic [3:0] ier_q;

    assign sel    = decode(req.addr);
    assign ie_tx  = ier_q[1];
    assign thr_wr = req.wr && (sel == SEL_THR);
    assign ack    = req.rd && (sel == SEL_IIR) && active;

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q  <= '0;
            wm_en  <= 1'b0;
            wm_lvl <= '0;
        end else if (req.wr) begin
            case (sel)
                SEL_IER:  ier_q  <= req.wdata[3:0];
                SEL_FEAT: wm_en  <= req.wdata[0];
                SEL_WMLV: wm_lvl <= req.wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_IER:  rdata = {4'b0, ier_q};
            SEL_IIR:  rdata = active ? IIR_TX : IIR_NONE;
            SEL_FEAT: rdata = {7'b0, wm_en};
            SEL_WMLV: rdata = wm_lvl;
            default:  rdata = 8'h00;
        endcase
    end

    p_iir_code_r8: assert property (@(posedge clk) disable iff (rst)
        (req.rd && sel == SEL_IIR) |-> (rdata == IIR_TX || rdata == IIR_NONE));
endmodule

// File: rtl/txwm_irq.sv
module txwm_irq
    import uart_txwm_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic             wm_en,
    input  logic [7:0]       wm_lvl,
    input  logic             ie,
    input  logic             ack,
    input  logic             thr_wr,
    output logic             irq_o
);
    logic cond, cond_q, ie_q, pend_q, arm;

    assign cond  = wm_en ? (int'(level) <= wm_sat(wm_lvl, DEPTH)) : (level == '0);
    assign arm   = cond && (!cond_q || (ie && !ie_q));
    assign irq_o = pend_q && cond && ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= 1'b1;
            ie_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            cond_q <= cond;
            ie_q   <= ie;
            if (!cond || ack || thr_wr) pend_q <= 1'b0;
            else if (arm)               pend_q <= 1'b1;
        end
    end

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (ack || thr_wr) |=> !irq_o);
    p_no_rearm_r10: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && cond_q && cond && ie_q && ie) |=> !pend_q);
endmodule

// File: rtl/uart_txwm.sv
module uart_txwm
    import uart_txwm_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [8:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic             tx_pop,
    output logic [7:0]       tx_data,
    output logic [LVL_W-1:0] tx_level,
    output logic             irq,
    output logic             tx_ovf
);
    bus_req_t   req;
    logic       ie_tx, wm_en, thr_wr, ack, full;
    logic [7:0] wm_lvl;

    assign req = '{rd: rd_en, wr: wr_en, addr: addr, wdata: wdata};

    txwm_regs u_regs (
        .clk(clk), .rst(rst), .req(req), .active(irq),
        .ie_tx(ie_tx), .wm_en(wm_en), .wm_lvl(wm_lvl),
        .thr_wr(thr_wr), .ack(ack), .rdata(rdata)
    );

    txwm_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(thr_wr), .din(wdata), .pop(tx_pop),
        .head(tx_data), .level(tx_level), .full(full), .ovf(tx_ovf)
    );

    txwm_irq #(.DEPTH(DEPTH)) u_irq (
        .clk(clk), .rst(rst), .level(tx_level), .wm_en(wm_en),
        .wm_lvl(wm_lvl), .ie(ie_tx), .ack(ack), .thr_wr(thr_wr), .irq_o(irq)
    );

    p_normal_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (!wm_en && irq) |-> (tx_level == '0));
    p_irq_full_r7: assert property (@(posedge clk) disable iff (rst)
        full |-> !irq);
endmodule

// File: tb/uart_txwm_test.sv
module uart_txwm_test;
    localparam int DEPTH = 32;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rd_en = 1'b0, wr_en = 1'b0, tx_pop = 1'b0;
    logic [8:0]       addr = '0;
    logic [7:0]       wdata = '0;
    logic [7:0]       rdata, tx_data;
    logic [LVL_W-1:0] tx_level;
    logic             irq, tx_ovf;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    uart_txwm #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tx_pop(tx_pop), .tx_data(tx_data),
        .tx_level(tx_level), .irq(irq), .tx_ovf(tx_ovf)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pop1();
        @(negedge clk);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq", int'(irq), 0);
        check("R1 level", int'(tx_level), 0);
        check("R1 ovf", int'(tx_ovf), 0);
        rd(9'h008, d);
        check("R1 iir", int'(d), 'hC1);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(9'h004, 8'hFD);
        rd(9'h004, d);
        check("R2 ier readback", int'(d), 'h0D);
        wr(9'h004, 8'h00);
        wr(9'h100, 8'hFF);
        rd(9'h100, d);
        check("R2 feature readback", int'(d), 'h01);
        wr(9'h100, 8'h00);
        wr(9'h104, 8'h5A);
        rd(9'h104, d);
        check("R2 watermark readback", int'(d), 'h5A);
        wr(9'h104, 8'h00);
        idle(2);
        check("R11 irq off while disabled", int'(irq), 0);
    endtask

    task automatic t_normal();
        logic [7:0] d;
        wr(9'h004, 8'h02);
        idle(2);
        check("R10 enable rise arms", int'(irq), 1);
        rd(9'h008, d);
        check("R8 iir tx code", int'(d), 'hC2);
        check("R9 read clears", int'(irq), 0);
        rd(9'h008, d);
        check("R8 iir none after ack", int'(d), 'hC1);
        wr(9'h000, 8'h11);
        check("R3 level after push", int'(tx_level), 1);
        check("R3 head", int'(tx_data), 'h11);
        idle(2);
        check("R5 not empty no irq", int'(irq), 0);
        pop1();
        idle(2);
        check("R5 empty raises irq", int'(irq), 1);
        wr(9'h000, 8'h22);
        check("R9 write clears", int'(irq), 0);
        pop1();
        idle(2);
        check("R5 empty again", int'(irq), 1);
        rd(9'h008, d);
        idle(3);
        check("R10 no rearm while holding", int'(irq), 0);
    endtask

    task automatic t_rearm_ie();
        logic [7:0] d;
        wr(9'h004, 8'h00);
        wr(9'h004, 8'h02);
        idle(2);
        check("R10 enable 0 to 1 rearms", int'(irq), 1);
        wr(9'h004, 8'h00);
        idle(1);
        check("R11 disable hides irq", int'(irq), 0);
        rd(9'h008, d);
        check("R11 iir none when disabled", int'(d), 'hC1);
        wr(9'h004, 8'h02);
        idle(2);
        rd(9'h008, d);
        idle(1);
    endtask

    task automatic t_wm();
        logic [7:0] d;
        wr(9'h100, 8'h01);
        wr(9'h104, 8'h04);
        for (int i = 1; i <= 6; i++) wr(9'h000, 8'(i));
        idle(2);
        check("R6 level 6 no irq", int'(irq), 0);
        pop1();
        idle(2);
        check("R6 level 5 above mark", int'(irq), 0);
        pop1();
        idle(2);
        check("R6 level 4 at mark", int'(irq), 1);
        check("R3 fifo order head", int'(tx_data), 3);
        rd(9'h008, d);
        check("R8 wm iir code", int'(d), 'hC2);
        pop1();
        idle(2);
        check("R10 below mark no rearm", int'(irq), 0);
        repeat (3) pop1();
        check("R3 drained", int'(tx_level), 0);
    endtask

    task automatic t_sat();
        logic [7:0] d;
        wr(9'h104, 8'hFF);
        rd(9'h104, d);
        check("R7 stored as is", int'(d), 'hFF);
        for (int i = 0; i < DEPTH; i++) wr(9'h000, 8'(i));
        check("R3 full level", int'(tx_level), DEPTH);
        idle(2);
        check("R7 full no irq", int'(irq), 0);
        wr(9'h000, 8'hEE);
        check("R4 level unchanged", int'(tx_level), DEPTH);
        check("R4 ovf set", int'(tx_ovf), 1);
        pop1();
        idle(2);
        check("R7 not full raises irq", int'(irq), 1);
        for (int i = 1; i < DEPTH; i++) begin
            check("R4 drain order", int'(tx_data), i);
            pop1();
        end
        check("R4 drained level", int'(tx_level), 0);
        check("R4 ovf sticky", int'(tx_ovf), 1);
    endtask

    initial begin
        #1_000_000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_regs();
        t_normal();
        t_rearm_ie();
        t_wm();
        t_sat();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule